// File: doc/BRIEF.md
# Fan PWM Driver with Duty Ramp

This block turns an 8-bit fan drive request into a single pulse-width modulated fan output. A 255-slot period counter is compared against the applied duty, so a duty value of `d` keeps the output high for `d` of every 255 slots. Duty 00h therefore gives a steady low output and FFh a steady high output, with no runt pulse at either end. The duty the counter uses is reloaded only when the period wraps. A duty change never cuts a pulse short.

The period counter advances in one of two ways. In the fast range it advances once every `HS_DIV` clock cycles, and the default is set for a PWM rate near 26 kHz. In the slow range it advances on every (`lo_div`+1)-th strobe of a reference tick derived from a 32.768 kHz source. The prescaler reaches rates from a few hertz up to roughly 128 Hz. Higher slow rates come from a faster reference strobe.

An optional slew limiter sits between the request and the period reload. When it is disabled, the request passes straight through. When it is enabled, the value passed on moves one code toward the request each time a programmable interval expires, and it stops exactly on the request.

Top module: `fan_pwm_drive`

## Requirements
- R1: While reset is asserted and immediately after its release, `pwm_out` is low and `duty_applied` is 00h.
- R2: In the fast range the period is 255 counter steps, each `HS_DIV` clock cycles long, and `pwm_out` is high for exactly `duty_applied` of those steps.
- R3: With `duty_applied` = 00h, `pwm_out` stays low for the whole period.
- R4: With `duty_applied` = FFh, `pwm_out` stays high for the whole period.
- R5: `duty_applied` changes only on the clock where the period counter wraps from 254 to 0. Successive changes in the fast range are therefore a whole multiple of 255×`HS_DIV` cycles apart.
- R6: With `ramp_en` low, `drive_req` becomes `duty_applied` at the first period wrap that comes two or more clocks after the request. There are no intermediate values.
- R7: In the slow range (`fast_sel` = 0), the counter steps once per (`lo_div`+1) strobes of `ref_tick`. With a strobe every 4 clocks, the period is 255×4×(`lo_div`+1) clocks and the high time is `duty_applied`×4×(`lo_div`+1) clocks.
- R8: With `ramp_en` high, the slewed value moves by exactly one code toward `drive_req` every `ramp_ivl`+1 clocks. It never passes the request and stays on it once reached.
- R9: With `ramp_en` high and `ramp_ivl`+1 longer than one period, each change of `duty_applied` is ±1 toward the request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| ref_tick | input | 1 | One-clock strobe at the reference rate, used in the slow range |
| drive_req | input | 8 | Requested duty code, 00h off to FFh full on |
| fast_sel | input | 1 | 1 selects the fast range, 0 the slow prescaled range |
| lo_div | input | PRE_W | Slow-range prescale; the counter steps every lo_div+1 strobes |
| ramp_en | input | 1 | 1 enables the slew limiter |
| ramp_ivl | input | IVL_W | Slew interval; one code step every ramp_ivl+1 clocks |
| pwm_out | output | 1 | Fan PWM output, active high |
| duty_applied | output | 8 | Duty code in use for the current period |

## Verification
The bench builds the block with `HS_DIV` = 1, so one fast period is exactly 255 clocks. This makes pulse widths directly countable, and the spacing of duty reloads can be checked as a multiple of 255. `PRE_W` = 4 allows a slow divide of 3 on a 4-clock reference strobe, so a slow period is 3060 clocks, and the prescaler is also run at a divide of 1. `IVL_W` = 10 allows a slew interval of 300 clocks. That interval is longer than a period, so every reload can be seen to differ from the one before by a single code, both upward and downward.

// File: rtl/fan_pwm_pkg.sv
package fan_pwm_pkg;
  localparam int DUTY_W  = 8;
  localparam int CNT_MAX = (1 << DUTY_W) - 2;  // 255 slots: 0 .. 254

  typedef logic [DUTY_W-1:0] duty_t;

  // one code toward the goal, never past it
  function automatic duty_t step_toward(input duty_t cur, input duty_t goal);
    if (cur < goal)      return cur + duty_t'(1);
    else if (cur > goal) return cur - duty_t'(1);
    else                 return cur;
  endfunction
endpackage

// File: rtl/fan_pwm_tick.sv
module fan_pwm_tick
  import fan_pwm_pkg::*;
#(
  parameter int HS_DIV = 15,
  parameter int PRE_W  = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             fast_sel,
  input  logic             ref_tick,
  input  logic [PRE_W-1:0] lo_div,
  output logic             step_o
);
  logic             hs_tick;
  logic [PRE_W-1:0] pre_cnt, pre_nx;
  logic             pre_hit;

  generate
    if (HS_DIV <= 1) begin : g_hs_direct
      assign hs_tick = 1'b1;
    end else begin : g_hs_div
      localparam int HS_W = $clog2(HS_DIV);
      logic [HS_W-1:0] hs_cnt, hs_nx;
      always_comb begin
        if (hs_cnt == HS_W'(HS_DIV - 1)) hs_nx = '0;
        else                             hs_nx = hs_cnt + HS_W'(1);
      end
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) hs_cnt <= '0;
        else        hs_cnt <= hs_nx;
      end
      assign hs_tick = (hs_cnt == HS_W'(HS_DIV - 1));
    end
  endgenerate

  assign pre_hit = ref_tick && (pre_cnt >= lo_div);

  always_comb begin
    pre_nx = pre_cnt;
    if (fast_sel)      pre_nx = '0;
    else if (pre_hit)  pre_nx = '0;
    else if (ref_tick) pre_nx = pre_cnt + PRE_W'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pre_cnt <= '0;
    else        pre_cnt <= pre_nx;
  end

  assign step_o = fast_sel ? hs_tick : pre_hit;
endmodule

// File: rtl/fan_pwm_slew.sv
module fan_pwm_slew
  import fan_pwm_pkg::*;
#(
  parameter int IVL_W = 12
) (
  input  logic             clk,
  input  logic             rst_n,
  input  duty_t            goal_i,
  input  logic             ramp_en,
  input  logic [IVL_W-1:0] ramp_ivl,
  output duty_t            slew_o
);
  logic [IVL_W-1:0] ivl_cnt, ivl_nx;
  logic             expire;
  duty_t            cur, cur_nx;

  assign expire = ramp_en && (ivl_cnt >= ramp_ivl);

  always_comb begin
    if (!ramp_en)    ivl_nx = '0;
    else if (expire) ivl_nx = '0;
    else             ivl_nx = ivl_cnt + IVL_W'(1);
  end

  always_comb begin
    if (!ramp_en)    cur_nx = goal_i;
    else if (expire) cur_nx = step_toward(cur, goal_i);
    else             cur_nx = cur;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ivl_cnt <= '0;
      cur     <= '0;
    end else begin
      ivl_cnt <= ivl_nx;
      cur     <= cur_nx;
    end
  end

  assign slew_o = cur;
endmodule

// File: rtl/fan_pwm_core.sv
module fan_pwm_core
  import fan_pwm_pkg::*;
(
  input  logic  clk,
  input  logic  rst_n,
  input  logic  step_i,
  input  duty_t duty_i,
  output duty_t duty_o,
  output duty_t pos_o,
  output logic  wrap_o,
  output logic  pwm_o
);
  duty_t pos, pos_nx;
  duty_t duty, duty_nx;
  logic  wrap;

  assign wrap = step_i && (pos == duty_t'(CNT_MAX));

  always_comb begin
    pos_nx  = pos;
    duty_nx = duty;
    if (wrap) begin
      pos_nx  = '0;
      duty_nx = duty_i;
    end else if (step_i) begin
      pos_nx  = pos + duty_t'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pos  <= '0;
      duty <= '0;
    end else begin
      pos  <= pos_nx;
      duty <= duty_nx;
    end
  end

  assign pwm_o  = (pos < duty);
  assign duty_o = duty;
  assign pos_o  = pos;
  assign wrap_o = wrap;
endmodule

// File: rtl/fan_pwm_drive.sv
module fan_pwm_drive
  import fan_pwm_pkg::*;
#(
  parameter int HS_DIV = 15,
  parameter int PRE_W  = 8,
  parameter int IVL_W  = 12
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ref_tick,
  input  logic [7:0]       drive_req,
  input  logic             fast_sel,
  input  logic [PRE_W-1:0] lo_div,
  input  logic             ramp_en,
  input  logic [IVL_W-1:0] ramp_ivl,
  output logic             pwm_out,
  output logic [7:0]       duty_applied
);
  logic [1:0] rst_sync;
  logic       rst_q_n;
  logic       step;
  duty_t      slew_duty;
  duty_t      period_pos;
  logic       period_wrap;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync <= '0;
    else        rst_sync <= {rst_sync[0], 1'b1};
  end
  assign rst_q_n = rst_sync[1];

  fan_pwm_tick #(.HS_DIV(HS_DIV), .PRE_W(PRE_W)) u_tick (
    .clk      (clk),
    .rst_n    (rst_q_n),
    .fast_sel (fast_sel),
    .ref_tick (ref_tick),
    .lo_div   (lo_div),
    .step_o   (step)
  );

  fan_pwm_slew #(.IVL_W(IVL_W)) u_slew (
    .clk      (clk),
    .rst_n    (rst_q_n),
    .goal_i   (drive_req),
    .ramp_en  (ramp_en),
    .ramp_ivl (ramp_ivl),
    .slew_o   (slew_duty)
  );

  fan_pwm_core u_core (
    .clk    (clk),
    .rst_n  (rst_q_n),
    .step_i (step),
    .duty_i (slew_duty),
    .duty_o (duty_applied),
    .pos_o  (period_pos),
    .wrap_o (period_wrap),
    .pwm_o  (pwm_out)
  );
endmodule

// File: rtl/fan_pwm_chk.sv
module fan_pwm_chk
  import fan_pwm_pkg::*;
(
  input logic       clk,
  input logic       rst_n,
  input logic       pwm_out,
  input logic [7:0] duty_applied,
  input logic [7:0] drive_req,
  input logic       ramp_en,
  input logic [7:0] slew_duty,
  input logic [7:0] period_pos,
  input logic       period_wrap
);
  assert_pos_range_R2: assert property (@(posedge clk) disable iff (!rst_n)
    period_pos <= 8'(CNT_MAX));

  assert_zero_low_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (duty_applied == 8'h00) |-> !pwm_out);

  assert_full_high_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (duty_applied == 8'hFF) |-> pwm_out);

  assert_reload_at_wrap_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !period_wrap |=> $stable(duty_applied));

  assert_single_step_R8: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(ramp_en) && ramp_en) |->
      (slew_duty == $past(slew_duty)) ||
      (slew_duty == $past(slew_duty) + 8'd1) ||
      (slew_duty == $past(slew_duty) - 8'd1));

  assert_no_overshoot_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (ramp_en && slew_duty <= drive_req && $stable(drive_req)) |=>
      (slew_duty <= $past(drive_req)));
endmodule

bind fan_pwm_drive fan_pwm_chk u_chk (
  .clk          (clk),
  .rst_n        (rst_q_n),
  .pwm_out      (pwm_out),
  .duty_applied (duty_applied),
  .drive_req    (drive_req),
  .ramp_en      (ramp_en),
  .slew_duty    (slew_duty),
  .period_pos   (period_pos),
  .period_wrap  (period_wrap)
);

// File: tb/fan_pwm_drive_tb.sv
module fan_pwm_drive_tb;
  localparam int PRE_W = 4;
  localparam int IVL_W = 10;
  localparam int PER   = 255;
  localparam int NVEC  = 6;
  // duty code; expected high clocks per fast period equals the code
  localparam logic [7:0] VEC [NVEC] = '{8'h00, 8'h01, 8'h40, 8'h80, 8'hFE, 8'hFF};

  logic             clk = 1'b0;
  logic             rst_n;
  logic             ref_tick;
  logic [7:0]       drive_req;
  logic             fast_sel;
  logic [PRE_W-1:0] lo_div;
  logic             ramp_en;
  logic [IVL_W-1:0] ramp_ivl;
  logic             pwm_out;
  logic [7:0]       duty_applied;

  int errors = 0;
  int checks = 0;
  int cyc    = 0;
  bit done   = 1'b0;

  always #2 clk = ~clk;

  fan_pwm_drive #(.HS_DIV(1), .PRE_W(PRE_W), .IVL_W(IVL_W)) u_dut (
    .clk (clk), .rst_n (rst_n), .ref_tick (ref_tick), .drive_req (drive_req),
    .fast_sel (fast_sel), .lo_div (lo_div), .ramp_en (ramp_en),
    .ramp_ivl (ramp_ivl), .pwm_out (pwm_out), .duty_applied (duty_applied)
  );

  initial forever begin
    @(posedge clk);
    cyc++;
  end

  initial begin
    ref_tick = 1'b0;
    forever begin
      for (int k = 0; k < 4; k++) begin
        @(negedge clk);
        ref_tick = (k == 3);
      end
    end
  end

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic wait_duty(input logic [7:0] v, input int lim, output bit ok);
    ok = 1'b0;
    for (int i = 0; i < lim; i++) begin
      @(negedge clk);
      if (duty_applied == v) begin ok = 1'b1; break; end
    end
  endtask

  task automatic wait_change(input int lim, output logic [7:0] v, output int t);
    logic [7:0] old;
    old = duty_applied;
    v = old; t = -1;
    for (int i = 0; i < lim; i++) begin
      @(negedge clk);
      if (duty_applied != old) begin v = duty_applied; t = cyc; break; end
    end
  endtask

  task automatic count_high(input int n, output int hi);
    hi = 0;
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      if (pwm_out) hi++;
    end
  endtask

  task automatic finish_run();
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  initial begin
    #(4 * 150000);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      finish_run();
    end
  end

  initial begin
    bit ok;
    int hi, t0, t;
    logic [7:0] v, prev;

    rst_n = 1'b0; drive_req = 8'h00; fast_sel = 1'b1; lo_div = '0;
    ramp_en = 1'b0; ramp_ivl = '0;
    repeat (3) @(negedge clk);
    check("R1 pwm in reset", int'(pwm_out), 0);
    check("R1 duty in reset", int'(duty_applied), 0);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    check("R1 pwm after release", int'(pwm_out), 0);
    check("R1 duty after release", int'(duty_applied), 0);

    // table walk: fast range, no slew (R2, R3, R4, R6)
    for (int i = 0; i < NVEC; i++) begin
      drive_req = VEC[i];
      wait_duty(VEC[i], 3 * PER, ok);
      check("R6 duty reaches request", int'(duty_applied), int'(VEC[i]));
      count_high(PER, hi);
      if (VEC[i] == 8'h00)      check("R3 steady low", hi, 0);
      else if (VEC[i] == 8'hFF) check("R4 steady high", hi, PER);
      else                      check("R2 high slots", hi, int'(VEC[i]));
    end

    // slow range, divide 3 on a 4-clock strobe (R7)
    drive_req = 8'h10; fast_sel = 1'b0; lo_div = 4'd2;
    wait_duty(8'h10, 4 * 3060, ok);
    check("R7 slow duty reached", int'(duty_applied), 16);
    count_high(3060, hi);
    check("R7 slow high, divide 3", hi, 16 * 12);
    lo_div = 4'd0;
    repeat (1100) @(negedge clk);
    count_high(1020, hi);
    check("R7 slow high, divide 1", hi, 16 * 4);

    // back to fast; slew up by single codes (R8, R9, R5)
    fast_sel = 1'b1;
    repeat (600) @(negedge clk);
    ramp_ivl = 10'd299; ramp_en = 1'b1;
    @(negedge clk);
    drive_req = 8'h18;
    prev = duty_applied; t0 = -1;
    for (int s = 0; s < 8; s++) begin
      wait_change(4 * PER, v, t);
      check("R9 slew up one code", int'(v), int'(prev) + 1);
      if (t0 < 0) t0 = t;
      else        check("R5 reload on wrap", (t - t0) % PER, 0);
      prev = v;
    end
    repeat (1200) @(negedge clk);
    check("R8 stops on request", int'(duty_applied), 8'h18);

    // slew down
    drive_req = 8'h14;
    prev = duty_applied;
    for (int s = 0; s < 4; s++) begin
      wait_change(4 * PER, v, t);
      check("R9 slew down one code", int'(v), int'(prev) - 1);
      check("R5 reload on wrap", (t - t0) % PER, 0);
      prev = v;
    end
    repeat (1200) @(negedge clk);
    check("R8 stops on request down", int'(duty_applied), 8'h14);

    // bypass: slew off, one jump to the request (R6)
    ramp_en = 1'b0;
    drive_req = 8'hA0;
    wait_change(3 * PER, v, t);
    check("R6 direct jump", int'(v), 8'hA0);
    check("R5 reload on wrap", (t - t0) % PER, 0);
    count_high(PER, hi);
    check("R2 high slots after jump", hi, 8'hA0);

    finish_run();
  end
endmodule